// File: doc/BRIEF.md
# Registered ROM with Initialize Word

A read-only store of 2048 eight-bit words whose read data leaves through an edge-triggered output register. On each rising clock edge the word at the presented 11-bit address is captured, and the outputs show that captured word until the next edge. The contents are computed at elaboration, so the array needs no load path.

An active-low, level-sensitive initialize input acts as a 2049th location. While it is low, the outputs show a parameter word at once, with no clock needed. They keep showing it after release until the next rising edge brings array data back. Setting the word to all ones gives a preset, and all zeros gives a clear. An active-low output enable either gates the outputs at once (asynchronous mode) or is sampled at each rising edge (synchronous mode), chosen by a parameter. When the outputs are not driven, the data bus is parked at zero and a drive flag is low.

The register tracks its source with two states. `W_INIT` means the initialize word is shown. `W_ARRAY` means captured array data is shown. The transition `T_FORCE` (initialize low, asynchronous) enters `W_INIT` from either state. The transition `T_LOAD` (rising edge with initialize high) enters `W_ARRAY` from either state. A rising edge while initialize is low stays in `W_INIT`.

Top module: `regrom`

## Requirements
- R1: The word at address a is the low 8 bits of ((a*29 + (a>>8)*71) XOR 0xA5), computed in 32-bit unsigned arithmetic.
- R2: The output shows the word addressed at the most recent rising edge taken with initialize high. Address changes between edges do not alter the output.
- R3: While init_n is low, the output shows INIT_WORD (default 0x3C) at once, without a clock edge.
- R4: Rising edges taken while init_n is low keep INIT_WORD on the output.
- R5: After init_n rises, INIT_WORD stays on the output until the next rising edge, which loads array data.
- R6: With SYNC_OE=0, dout_drv equals NOT oe_n at all times, with no clock involved.
- R7: With SYNC_OE=1, dout_drv takes NOT oe_n as sampled at each rising edge. Changes to oe_n between edges have no effect.
- R8: With SYNC_OE=1, init_n does not change the registered enable. The enable keeps sampling oe_n at edges while init_n is low.
- R9: When dout_drv is 0, dout reads 8'h00.
- R10: With SYNC_OE=1, the outputs are not driven from power-up until the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| init_n | input | 1 | Active-low level initialize, forces INIT_WORD |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 11 | Word address |
| dout | output | 8 | Data bus, zero when not driven |
| dout_drv | output | 1 | High when the data bus is driven |

## Verification
If the source state is wrong, the wrong thing appears in the first half cycle after the fault. An initialize word shows up where array data belongs, or array data shows up where the initialize word belongs. A mis-captured address shows as a wrong word at the next falling edge after the capture. A fault in the enable path shows either as a drive flag that follows oe_n mid-cycle in synchronous mode, or as one that lags by an edge in asynchronous mode. The bench watches both enable variants side by side under the same stimulus.

// File: rtl/regrom_pkg.sv
package regrom_pkg;

    typedef enum logic {
        W_INIT  = 1'b0,
        W_ARRAY = 1'b1
    } src_e;

    function automatic logic [31:0] rom_word(input int unsigned a);
        logic [31:0] v;
        v = (32'(a) * 32'd29 + (32'(a) >> 8) * 32'd71) ^ 32'h0000_00A5;
        return v;
    endfunction

endpackage

// File: rtl/regrom_array.sv
module regrom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [31:0] FULL = regrom_pkg::rom_word(g);
        assign cells[g] = FULL[DATA_W-1:0];
    end

    assign rd_word = cells[rd_addr];

endmodule

// File: rtl/regrom_word_reg.sv
module regrom_word_reg #(
    parameter int                 DATA_W    = 8,
    parameter logic [DATA_W-1:0]  INIT_WORD = 8'h3C
) (
    input  logic              clk,
    input  logic              init_n,
    input  logic [DATA_W-1:0] arr_word,
    output regrom_pkg::src_e  src,
    output logic [DATA_W-1:0] word_o
);
    import regrom_pkg::*;

    src_e              src_q;
    src_e              src_nx;
    logic [DATA_W-1:0] arr_q;

    // next state on a clean rising edge: T_LOAD from either state
    always_comb begin
        unique case (src_q)
            W_INIT:  src_nx = W_ARRAY;
            W_ARRAY: src_nx = W_ARRAY;
            default: src_nx = W_ARRAY;
        endcase
    end

    // state register: T_FORCE is asynchronous and level sensitive
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) src_q <= W_INIT;
        else         src_q <= src_nx;
    end

    // array data is captured at every edge; the state picks what is shown
    always_ff @(posedge clk) begin
        arr_q <= arr_word;
    end

    // output process
    always_comb begin
        unique case (src_q)
            W_INIT:  word_o = INIT_WORD;
            W_ARRAY: word_o = arr_q;
            default: word_o = INIT_WORD;
        endcase
    end

    assign src = src_q;

endmodule

// File: rtl/regrom_oe.sv
module regrom_oe #(
    parameter bit SYNC_OE = 1'b0
) (
    input  logic clk,
    input  logic oe_n,
    output logic drv
);
    if (SYNC_OE) begin : g_sync
        logic en_q = 1'b0;
        always_ff @(posedge clk) begin
            en_q <= !oe_n;
        end
        assign drv = en_q;
    end else begin : g_async
        assign drv = !oe_n;
    end

endmodule

// File: rtl/regrom.sv
module regrom #(
    parameter int                ADDR_W    = 11,
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = 8'h3C,
    parameter bit                SYNC_OE   = 1'b0
) (
    input  logic              clk,
    input  logic              init_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drv
);
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] shown;
    regrom_pkg::src_e  word_src;
    logic              drv;

    regrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .rd_addr (addr),
        .rd_word (rd_word)
    );

    regrom_word_reg #(.DATA_W(DATA_W), .INIT_WORD(INIT_WORD)) u_reg (
        .clk      (clk),
        .init_n   (init_n),
        .arr_word (rd_word),
        .src      (word_src),
        .word_o   (shown)
    );

    regrom_oe #(.SYNC_OE(SYNC_OE)) u_oe (
        .clk  (clk),
        .oe_n (oe_n),
        .drv  (drv)
    );

    assign dout     = drv ? shown : '0;
    assign dout_drv = drv;

endmodule

// File: rtl/regrom_chk.sv
module regrom_chk #(
    parameter int                ADDR_W    = 11,
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = 8'h3C,
    parameter bit                SYNC_OE   = 1'b0
) (
    input logic              clk,
    input logic              init_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_drv,
    input regrom_pkg::src_e  src
);
    import regrom_pkg::*;

    logic              started = 1'b0;
    logic [ADDR_W-1:0] edge_addr;
    logic [31:0]       ref_full;

    always_ff @(posedge clk) begin
        started   <= 1'b1;
        edge_addr <= addr;
    end

    assign ref_full = rom_word(32'(edge_addr));

    // R1 R2
    array_word_chk: assert property (@(negedge clk) disable iff (!init_n)
        (started && src == W_ARRAY && dout_drv) |-> dout == ref_full[DATA_W-1:0]);

    // R3
    init_force_chk: assert property (@(negedge clk) disable iff (!started)
        !init_n |-> src == W_INIT);

    // R5
    init_word_chk: assert property (@(negedge clk) disable iff (!started)
        (src == W_INIT && dout_drv) |-> dout == INIT_WORD);

    // R9
    park_zero_chk: assert property (@(negedge clk) disable iff (!started)
        !dout_drv |-> dout == '0);

    if (SYNC_OE) begin : g_sync
        // R7 R8
        sync_en_chk: assert property (@(posedge clk) disable iff (!started)
            dout_drv == !$past(oe_n));
    end else begin : g_async
        // R6
        async_en_chk: assert property (@(posedge clk) disable iff (!started)
            dout_drv == !oe_n);
    end

endmodule

bind regrom regrom_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_WORD(INIT_WORD), .SYNC_OE(SYNC_OE)
) u_chk (
    .clk(clk), .init_n(init_n), .oe_n(oe_n), .addr(addr),
    .dout(dout), .dout_drv(dout_drv), .src(word_src)
);

// File: tb/tb_regrom.sv
module tb_regrom;
    localparam logic [7:0] IW = 8'h3C;

    logic        clk = 1'b0;
    logic        init_n;
    logic        oe_n;
    logic [10:0] addr;
    logic [7:0]  dout_a, dout_s;
    logic        drv_a, drv_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] dat;
        logic       da;
        logic       ds;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t last;

    always #10 clk = ~clk;

    regrom #(.INIT_WORD(IW), .SYNC_OE(1'b0)) dut (
        .clk(clk), .init_n(init_n), .oe_n(oe_n), .addr(addr),
        .dout(dout_a), .dout_drv(drv_a)
    );

    regrom #(.INIT_WORD(IW), .SYNC_OE(1'b1)) dut_s (
        .clk(clk), .init_n(init_n), .oe_n(oe_n), .addr(addr),
        .dout(dout_s), .dout_drv(drv_s)
    );

    // R1: reference content from the stated formula
    function automatic logic [7:0] exp_word(input int a);
        int v;
        v = (a * 29 + (a >> 8) * 71) ^ 32'hA5;
        return v[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: present inputs at the falling edge, predict the next edge
    task automatic step(input int a, input logic oe, input string req);
        exp_t e;
        @(negedge clk);
        addr = 11'(a);
        oe_n = oe;
        e.dat = init_n ? exp_word(a) : IW;
        e.da  = !oe;
        e.ds  = !oe;
        e.req = req;
        q.push_back(e);
        last = e;
    endtask

    task automatic drain();
        @(posedge clk);
        #6;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " async drv"}, 8'(drv_a), 8'(e.da));
                check({e.req, " async dout"}, dout_a, e.da ? e.dat : 8'h00);
                check({e.req, " sync drv"}, 8'(drv_s), 8'(e.ds));
                check({e.req, " sync dout"}, dout_s, e.ds ? e.dat : 8'h00);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        init_n = 1'b0;
        oe_n   = 1'b0;
        addr   = '0;
        #1;
        check("R3 reset async dout", dout_a, IW);
        check("R6 reset async drv", 8'(drv_a), 8'h01);
        check("R10 sync drv before first edge", 8'(drv_s), 8'h00);
        check("R9 sync dout parked", dout_s, 8'h00);

        step(5, 1'b0, "R4");
        step(6, 1'b1, "R4 R8 R9");
        step(7, 1'b0, "R4");
        drain();

        @(negedge clk);
        #3 init_n = 1'b1;
        #1;
        check("R5 async dout after release", dout_a, IW);
        check("R5 sync dout after release", dout_s, IW);

        step(0, 1'b0, "R1 R2 R5");
        step(2047, 1'b0, "R1 R2");
        step(1234, 1'b0, "R1 R2");
        step(1, 1'b1, "R7 R9");
        step(2, 1'b0, "R7");
        for (int i = 0; i < 40; i++) begin
            step((i * 53 + 17) % 2048, (i % 7) == 3, "R1 R2 R7");
        end
        drain();

        addr = addr ^ 11'h555;
        #2;
        check("R2 addr change async", dout_a, last.dat);
        check("R2 addr change sync", dout_s, last.dat);

        oe_n = ~oe_n;
        #1;
        check("R6 async drv follows", 8'(drv_a), 8'(!oe_n));
        check("R7 sync drv held", 8'(drv_s), 8'(last.ds));

        step(100, 1'b0, "R1 R2");
        drain();
        init_n = 1'b0;
        #1;
        check("R3 async forced mid-cycle", dout_a, IW);
        check("R3 sync forced mid-cycle", dout_s, IW);
        check("R8 sync drv kept by init", 8'(drv_s), 8'h01);

        step(200, 1'b1, "R4 R8");
        step(201, 1'b0, "R4 R8");
        drain();
        @(negedge clk);
        init_n = 1'b1;
        step(300, 1'b0, "R1 R2");
        step(2046, 1'b0, "R1 R2");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule